// File: doc/BRIEF.md
# Interleaved Peak-Current PWM Timing Core

This block produces the switch commands for a multi-phase boost power stage run under cycle-by-cycle peak current control. A free-running counter, sized from the system clock and the wanted switching rate, divides each switching period into equal phase slots. In its slot, each phase turns its switch on. An external comparator watches that phase's inductor current against a setpoint and raises a trip input. The trip ends the on-time, but only after a programmable blanking window that hides the turn-on current spike. A maximum on-time clamp ends any pulse that never trips. With the default of two phases, the second phase starts half a period after the first.

A break input forces every switch command low in the same cycle, without waiting for a clock edge, and keeps it low for the rest of the pulse. A strobe paces the outer voltage loop once every `STB_DIV` switching periods. The current setpoint word given to the external DAC is captured only on that strobe. Blanking length and maximum on-time are copied into per-phase shadow registers at each turn-on, so a change written in the middle of a pulse never alters that pulse.

Top module: `ipwm_pcm_gen`

## Requirements
- R1: While reset is held, every gate output is low, the loop strobe is low and the setpoint output is zero.
- R2: With a nonzero maximum on-time and no break, phase 0 turns on exactly once every PERIOD clock cycles (PERIOD = CLK_HZ / PWM_HZ).
- R3: Phase k turns on k*PERIOD/NPH cycles after phase 0; with two phases, phase 1 rises PERIOD/2 cycles after phase 0.
- R4: Number the high cycles of a pulse from 0. If the trip input is sampled high in high cycle t, and t is not less than the blanking length, the gate goes low after that cycle, giving a pulse t+1 cycles wide.
- R5: The trip is ignored during high cycles 0 through blanking length minus one, including a trip that is already high when the period starts. A trip held high all the time gives a pulse of blanking length plus one cycles (one cycle when the blanking length is zero).
- R6: A pulse that never trips lasts exactly the maximum on-time. The maximum is saturated to PERIOD-1, and a maximum of zero produces no pulse at all.
- R7: While break is high, every gate output is low in the same cycle. A pulse cut by break stays off after break falls, until that phase's next slot.
- R8: The loop strobe is high for exactly one cycle every STB_DIV*PERIOD cycles.
- R9: The setpoint output takes the setpoint input value from the strobe cycle, in the cycle after the strobe, and holds it unchanged at all other times.
- R10: The blanking length and maximum on-time take effect at each phase's next turn-on. A change made during a pulse does not alter that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| brk_i | input | 1 | Hardware break; forces all gates low at once |
| trip_i | input | NPH | Per-phase peak-current comparator trip |
| blank_i | input | CNT_W | Leading-edge blanking length in clock cycles |
| maxon_i | input | CNT_W | Maximum on-time in clock cycles |
| iset_i | input | SP_W | New current setpoint word from the outer loop |
| gate_o | output | NPH | Per-phase switch command, high = on |
| loop_stb_o | output | 1 | One-cycle outer-loop update strobe |
| iset_o | output | SP_W | Setpoint word captured on the strobe |

## Verification
Some properties are checked on every cycle. These are:
- Break forces the gates low in the same cycle.
- No gate stays high for a full period.
- Each rising gate edge lands in its own phase slot of the counter.
- Strobes are exactly STB_DIV*PERIOD cycles apart.
- The setpoint output moves only right after a strobe.

Other behaviour needs the scenarios of the bench. These include the exact pulse widths set by trip timing against the blanking window and the clamp, and the ignoring of trips that arrive during blanking. They also cover the shadowing of a mid-pulse change until the next turn-on, the zero-width case, and a cut pulse staying off after break is released.

// File: rtl/ipwm_pkg.sv
package ipwm_pkg;

   // Per-phase on-time state: switch off, on with trip masked, on with trip honoured.
   typedef enum logic [1:0] {
      PH_OFF   = 2'd0,
      PH_BLANK = 2'd1,
      PH_ARMED = 2'd2
   } ph_state_e;

   // Start offset of a phase inside the period.
   function automatic int slot_of(input int k, input int period, input int nph);
      return (k * period) / nph;
   endfunction

endpackage

// File: rtl/ipwm_timebase.sv
module ipwm_timebase #(
   parameter int PERIOD = 1000,
   parameter int NPH    = 2,
   parameter int CNT_W  = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o,
   output logic [NPH-1:0]   start_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                   cnt_q <= cnt_q + CNT_W'(1);
   end

   assign cnt_o  = cnt_q;
   assign wrap_o = (cnt_q == LAST);

   for (genvar k = 0; k < NPH; k++) begin : g_slot
      localparam int SLOT = ipwm_pkg::slot_of(k, PERIOD, NPH);
      assign start_o[k] = (cnt_q == CNT_W'(SLOT));
   end

endmodule

// File: rtl/ipwm_pacer.sv
module ipwm_pacer #(
   parameter int DIV  = 10,
   parameter int SP_W = 12
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            wrap_i,
   input  logic [SP_W-1:0] iset_i,
   output logic            stb_o,
   output logic [SP_W-1:0] iset_o
);
   logic            stb_q;
   logic [SP_W-1:0] iset_q;

   if (DIV == 1) begin : g_every
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) stb_q <= 1'b0;
         else         stb_q <= wrap_i;
      end
   end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] PLAST = PW'(DIV - 1);
      logic [PW-1:0] pcnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            pcnt_q <= '0;
            stb_q  <= 1'b0;
         end else begin
            stb_q <= wrap_i && (pcnt_q == PLAST);
            if (wrap_i) pcnt_q <= (pcnt_q == PLAST) ? '0 : pcnt_q + PW'(1);
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    iset_q <= '0;
      else if (stb_q) iset_q <= iset_i;
   end

   assign stb_o  = stb_q;
   assign iset_o = iset_q;

endmodule

// File: rtl/ipwm_phase.sv
module ipwm_phase
   import ipwm_pkg::*;
#(
   parameter int PERIOD = 1000,
   parameter int CNT_W  = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             brk_i,
   input  logic             trip_i,
   input  logic [CNT_W-1:0] blank_i,
   input  logic [CNT_W-1:0] maxon_i,
   output logic             gate_o
);
   localparam logic [CNT_W-1:0] ON_CAP = CNT_W'(PERIOD - 1);

   logic [CNT_W-1:0] max_in;
   logic [CNT_W-1:0] blank_q, max_q;
   logic [CNT_W-1:0] ton_q, ton_nx;
   ph_state_e        st_q;

   assign max_in = (maxon_i > ON_CAP) ? ON_CAP : maxon_i;
   assign ton_nx = ton_q + CNT_W'(1);

   // Shadow copies, refreshed only at this phase's turn-on slot.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         blank_q <= '0;
         max_q   <= '0;
      end else if (start_i) begin
         blank_q <= blank_i;
         max_q   <= max_in;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= PH_OFF;
         ton_q <= '0;
      end else if (brk_i) begin
         st_q  <= PH_OFF;
         ton_q <= '0;
      end else if (start_i) begin
         ton_q <= '0;
         if (max_in == '0)       st_q <= PH_OFF;
         else if (blank_i == '0) st_q <= PH_ARMED;
         else                    st_q <= PH_BLANK;
      end else begin
         unique case (st_q)
            PH_BLANK: begin
               ton_q <= ton_nx;
               if (ton_nx >= max_q)        st_q <= PH_OFF;
               else if (ton_nx >= blank_q) st_q <= PH_ARMED;
            end
            PH_ARMED: begin
               ton_q <= ton_nx;
               if (trip_i || (ton_nx >= max_q)) st_q <= PH_OFF;
            end
            default: ton_q <= '0;
         endcase
      end
   end

   assign gate_o = (st_q != PH_OFF) && !brk_i;

endmodule

// File: rtl/ipwm_pcm_gen.sv
module ipwm_pcm_gen #(
   parameter int CLK_HZ  = 100_000_000,
   parameter int PWM_HZ  = 100_000,
   parameter int NPH     = 2,
   parameter int STB_DIV = 10,
   parameter int CNT_W   = 10,
   parameter int SP_W    = 12
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             brk_i,
   input  logic [NPH-1:0]   trip_i,
   input  logic [CNT_W-1:0] blank_i,
   input  logic [CNT_W-1:0] maxon_i,
   input  logic [SP_W-1:0]  iset_i,
   output logic [NPH-1:0]   gate_o,
   output logic             loop_stb_o,
   output logic [SP_W-1:0]  iset_o
);
   localparam int PERIOD = CLK_HZ / PWM_HZ;

   if (NPH < 1) begin : g_bad_nph
      $error("NPH must be at least 1");
   end
   if (PERIOD < 2 * NPH) begin : g_bad_period
      $error("PERIOD too short for the phase count");
   end
   if ((2 ** CNT_W) <= PERIOD) begin : g_bad_cntw
      $error("CNT_W cannot hold PERIOD");
   end
   if (STB_DIV < 1) begin : g_bad_div
      $error("STB_DIV must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             wrap;
   logic [NPH-1:0]   start;

   ipwm_timebase #(.PERIOD(PERIOD), .NPH(NPH), .CNT_W(CNT_W)) u_tb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cnt_o  (cnt_q),
      .wrap_o (wrap),
      .start_o(start)
   );

   ipwm_pacer #(.DIV(STB_DIV), .SP_W(SP_W)) u_pace (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wrap_i (wrap),
      .iset_i (iset_i),
      .stb_o  (loop_stb_o),
      .iset_o (iset_o)
   );

   for (genvar k = 0; k < NPH; k++) begin : g_ph
      ipwm_phase #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_ph (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .start_i(start[k]),
         .brk_i  (brk_i),
         .trip_i (trip_i[k]),
         .blank_i(blank_i),
         .maxon_i(maxon_i),
         .gate_o (gate_o[k])
      );
   end

endmodule

// File: rtl/ipwm_pcm_chk.sv
module ipwm_pcm_chk #(
   parameter int PERIOD = 1000,
   parameter int NPH    = 2,
   parameter int DIV    = 10,
   parameter int CNT_W  = 10,
   parameter int SP_W   = 12
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             brk_i,
   input logic [NPH-1:0]   gate_o,
   input logic             loop_stb_o,
   input logic [SP_W-1:0]  iset_o,
   input logic [CNT_W-1:0] cnt_i
);
   localparam int GAP = DIV * PERIOD;

   int gap_q;
   logic seen_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gap_q  <= 0;
         seen_q <= 1'b0;
      end else if (loop_stb_o) begin
         gap_q  <= 0;
         seen_q <= 1'b1;
      end else begin
         gap_q <= gap_q + 1;
      end
   end

   // R7: break holds every gate low in the same cycle
   a_r7_break_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      brk_i |-> (gate_o == '0));

   // R8: strobe spacing
   a_r8_stb_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (loop_stb_o && seen_q) |-> (gap_q == GAP - 1));

   // R9: setpoint moves only right after a strobe
   a_r9_iset_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(loop_stb_o) |-> $stable(iset_o));

   for (genvar k = 0; k < NPH; k++) begin : g_ph
      localparam int SLOT = ipwm_pkg::slot_of(k, PERIOD, NPH);
      int run_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)        run_q <= 0;
         else if (gate_o[k]) run_q <= run_q + 1;
         else                run_q <= 0;
      end

      // R6: no pulse reaches a full period
      a_r6_max_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
         gate_o[k] |-> (run_q < PERIOD - 1));

      // R2 / R3: turn-on happens right after the phase slot
      a_r3_rise_in_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(gate_o[k]) |-> ($past(cnt_i) == CNT_W'(SLOT)));
   end

endmodule

bind ipwm_pcm_gen ipwm_pcm_chk #(
   .PERIOD(PERIOD), .NPH(NPH), .DIV(STB_DIV), .CNT_W(CNT_W), .SP_W(SP_W)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .brk_i     (brk_i),
   .gate_o    (gate_o),
   .loop_stb_o(loop_stb_o),
   .iset_o    (iset_o),
   .cnt_i     (cnt_q)
);

// File: tb/sim_ipwm_pcm_gen.sv
`timescale 1ns/1ps
module sim_ipwm_pcm_gen;
   localparam int P    = 40;
   localparam int DIV  = 10;
   localparam int CW   = 10;
   localparam int SPW  = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic brk = 1'b0;
   logic [1:0] trip = 2'b00;
   logic [CW-1:0] blank = '0;
   logic [CW-1:0] maxon = '0;
   logic [SPW-1:0] iset = '0;
   logic [1:0] gate;
   logic stb;
   logic [SPW-1:0] iset_out;

   always #10 clk = ~clk;

   ipwm_pcm_gen #(.CLK_HZ(50_000_000), .PWM_HZ(1_250_000), .NPH(2),
                  .STB_DIV(DIV), .CNT_W(CW), .SP_W(SPW)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .brk_i(brk), .trip_i(trip),
      .blank_i(blank), .maxon_i(maxon), .iset_i(iset),
      .gate_o(gate), .loop_stb_o(stb), .iset_o(iset_out));

   int n_chk = 0, n_fail = 0;
   logic done = 1'b0;
   string cur_req = "R6";
   int trip_mode = 0, trip_at = 0;
   int q0[$], q1[$];
   int run[2] = '{0, 0};
   int rise[2] = '{0, 0};
   int prise[2] = '{0, 0};
   int nrise[2] = '{0, 0};
   int cyc = 0, nstb = 0, last_stb = 0, prev_stb = 0;
   logic [SPW-1:0] stb_val = '0;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // expected pulse width from the requirements
   function automatic int expw(input int mode, input int bl, input int mx, input int at);
      int m, k;
      m = (mx > P - 1) ? P - 1 : mx;
      if (mode == 0) return m;
      k = (mode == 1) ? bl : ((at > bl) ? at : bl);
      return (k < m) ? k + 1 : m;
   endfunction

   // monitor: pulse widths, rise times, strobes; also drives trip
   always @(negedge clk) begin
      cyc++;
      for (int k = 0; k < 2; k++) begin
         if (gate[k]) begin
            if (run[k] == 0) begin
               prise[k] = rise[k];
               rise[k]  = cyc;
               nrise[k]++;
            end
            run[k]++;
         end else if (run[k] != 0) begin
            if (k == 0 && q0.size() > 0) chk({cur_req, " width ph0"}, run[k], q0.pop_front());
            if (k == 1 && q1.size() > 0) chk({cur_req, " width ph1"}, run[k], q1.pop_front());
            run[k] = 0;
         end
         if (trip_mode == 1)      trip[k] = 1'b1;
         else if (trip_mode == 2) trip[k] = gate[k] && (run[k] >= trip_at + 1);
         else                     trip[k] = 1'b0;
      end
      if (stb) begin
         prev_stb = last_stb;
         last_stb = cyc;
         nstb++;
         stb_val = iset;
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #5;
   endtask

   task automatic scen(input string req, input int mode, input int bl, input int mx, input int at);
      int w;
      trip_mode = mode; trip_at = at;
      blank = CW'(bl); maxon = CW'(mx);
      cur_req = req;
      step(2 * P);
      w = expw(mode, bl, mx, at);
      for (int i = 0; i < 3; i++) begin q0.push_back(w); q1.push_back(w); end
      step(4 * P);
      chk({req, " pulses seen"}, q0.size() + q1.size(), 0);
   endtask

   initial begin
      int n, d, a;
      blank = CW'(2); maxon = CW'(10);
      step(3);
      // R1 reset state
      chk("R1 gates", int'(gate), 0);
      chk("R1 strobe", int'(stb), 0);
      chk("R1 setpoint", int'(iset_out), 0);
      rst_n = 1'b1;

      scen("R6 plain", 0, 2, 10, 0);
      scen("R6 clamp", 0, 2, 60, 0);
      scen("R5 trip held", 1, 3, 20, 0);
      scen("R5 zero blank", 1, 0, 20, 0);
      scen("R4 late trip", 2, 4, 30, 8);
      scen("R4 R5 early trip", 2, 6, 30, 2);
      scen("R6 trip past max", 2, 2, 20, 25);

      // R2 / R3 slot timing
      chk("R2 period", rise[0] - prise[0], P);
      d = rise[1] - rise[0];
      if (d < 0) d += P;
      chk("R3 offset", d, P / 2);

      // R10 mid-pulse change
      scen("R10 setup", 0, 2, 10, 0);
      do step(1); while (run[0] != 3);
      maxon = CW'(5);
      cur_req = "R10";
      q0.push_back(10); q0.push_back(5); q0.push_back(5);
      step(4 * P);
      chk("R10 pulses seen", q0.size(), 0);

      // R6 zero maximum: no pulse
      maxon = '0;
      step(2 * P);
      n = nrise[0] + nrise[1];
      step(3 * P);
      chk("R6 zero max rises", nrise[0] + nrise[1] - n, 0);

      // R7 break
      maxon = CW'(30); trip_mode = 0;
      step(2 * P);
      do step(1); while (run[0] != 5);
      brk = 1'b1; #1;
      chk("R7 gates at break", int'(gate), 0);
      step(2);
      chk("R7 gates held", int'(gate), 0);
      brk = 1'b0; #1;
      chk("R7 stays off after release", int'(gate[0]), 0);
      step(5);
      chk("R7 still off", int'(gate[0]), 0);
      scen("R7 recovery", 0, 2, 10, 0);

      // R8 / R9 strobe and setpoint
      iset = 12'h3A7;
      n = nstb;
      do step(1); while (nstb == n);
      chk("R8 single cycle", int'(stb), 0);
      a = int'(stb_val);
      chk("R9 captured", int'(iset_out), a);
      iset = 12'h0C4;
      step(100);
      chk("R9 held between strobes", int'(iset_out), a);
      n = nstb;
      do step(1); while (nstb == n);
      chk("R8 spacing", last_stb - prev_stb, DIV * P);
      chk("R9 new value", int'(iset_out), 12'h0C4);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog (all requirements): actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule